// File: doc/BRIEF.md
# Programmable UART FIFO Interrupt Triggers

This block produces two interrupt requests for a UART whose receive and transmit FIFOs each hold 128 characters. The receive request tells software that enough characters are waiting. The transmit request tells software that the transmit FIFO needs refilling. Each request comes with a fixed priority code, so the surrounding interrupt identification logic can rank it against other sources.

In enhanced mode, each request compares a FIFO fill level against a 7-bit threshold. Software writes the two thresholds through a small register port with one address bit. Writing a transmit threshold of zero changes the transmit condition: the request then means that the transmitter has fully drained and the serial line is idle. In legacy mode, the programmed thresholds are not used. Each threshold instead comes from a fixed table selected by a 2-bit field.

The outputs are combinational functions of the fill levels, the enables and the stored thresholds. A request therefore changes in the same cycle as the level that caused it.

Top module: `uart_fifo_irq_trig`

## Requirements
- R1: With `enh_en`=1, `rx_irq` is 1 exactly when `rx_ie`=1 and `rx_level` is greater than or equal to the programmed receive threshold.
- R2: With `enh_en`=1 and a nonzero transmit threshold, `tx_irq` is 1 exactly when `tx_ie`=1 and `tx_level` is less than the programmed transmit threshold.
- R3: With `enh_en`=1 and a transmit threshold of 0, `tx_irq` is 1 exactly when all of the following hold: `tx_ie`=1, `tx_level`=0, `tsr_empty`=1 and `line_idle`=1.
- R4: With `enh_en`=1, the fields `rx_lvl_sel` and `tx_lvl_sel` have no effect on either request.
- R5: With `enh_en`=0, the receive threshold comes from `rx_lvl_sel`: 0 gives 1, 1 gives 32, 2 gives 64, 3 gives 112. `rx_irq` is then `rx_ie` AND (`rx_level` >= that value). The programmed registers are not used.
- R6: With `enh_en`=0, the transmit threshold comes from `tx_lvl_sel`: 0 gives 16, 1 gives 32, 2 gives 64, 3 gives 112. `tx_irq` is then `tx_ie` AND (`tx_level` < that value). There is no special case for zero in this mode.
- R7: `rx_prio` is 2 while `rx_irq` is 1 and 0 otherwise. `tx_prio` is 3 while `tx_irq` is 1 and 0 otherwise.
- R8: The requests and priority codes follow their inputs within the same cycle. A request falls as soon as its condition stops holding.
- R9: A cycle with `reg_we`=1 stores `reg_wdata` in the receive threshold when `reg_addr`=0, or in the transmit threshold when `reg_addr`=1. The new value is used from the next cycle on.
- R10: A synchronous `rst` sets both thresholds to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Threshold write strobe |
| reg_addr | input | 1 | 0 selects the receive threshold, 1 selects the transmit threshold |
| reg_wdata | input | 7 | Threshold write data |
| enh_en | input | 1 | 1 selects programmed thresholds, 0 selects the legacy table |
| rx_lvl_sel | input | 2 | Legacy receive trigger select |
| tx_lvl_sel | input | 2 | Legacy transmit trigger select |
| rx_ie | input | 1 | Receive interrupt enable |
| tx_ie | input | 1 | Transmit interrupt enable |
| rx_level | input | 8 | Receive FIFO fill level, 0 to 128 |
| tx_level | input | 8 | Transmit FIFO fill level, 0 to 128 |
| tsr_empty | input | 1 | Transmit shift register empty |
| line_idle | input | 1 | Serial output is idle in the mark state |
| rx_irq | output | 1 | Receive data available request |
| tx_irq | output | 1 | Transmit holding request |
| rx_prio | output | 2 | Priority code of the receive request |
| tx_prio | output | 2 | Priority code of the transmit request |

## Verification
The assertions assume that both fill levels stay within 0 to 128. They also assume that the legacy fields, enables and levels are clean 0/1 values driven between clock edges. The bench changes its inputs only just after a rising edge, and it draws levels only from that range. The bench covers the boundaries at each threshold and its neighbours. It covers all eight combinations of drained level, shift register state and line state. It also interleaves threshold writes, including zero, with random mode and level changes.

// File: rtl/uart_trig_pkg.sv
package uart_trig_pkg;
  localparam int unsigned THR_BITS = 7;
  localparam int unsigned RX_IDX   = 0;
  localparam int unsigned TX_IDX   = 1;
  localparam logic [1:0]  RX_PRIO  = 2'd2;
  localparam logic [1:0]  TX_PRIO  = 2'd3;

  // Fixed receive trigger table used in legacy mode
  function automatic logic [THR_BITS-1:0] legacy_rx_thr(input logic [1:0] sel);
    case (sel)
      2'd0:    return THR_BITS'(1);
      2'd1:    return THR_BITS'(32);
      2'd2:    return THR_BITS'(64);
      default: return THR_BITS'(112);
    endcase
  endfunction

  // Fixed transmit trigger table used in legacy mode
  function automatic logic [THR_BITS-1:0] legacy_tx_thr(input logic [1:0] sel);
    case (sel)
      2'd0:    return THR_BITS'(16);
      2'd1:    return THR_BITS'(32);
      2'd2:    return THR_BITS'(64);
      default: return THR_BITS'(112);
    endcase
  endfunction
endpackage

// File: rtl/trig_thr_regs.sv
module trig_thr_regs #(
  parameter int unsigned THR_W     = 7,
  parameter int unsigned NUM_THR   = 2,
  parameter int unsigned RESET_VAL = 1,
  localparam int unsigned ADDR_W   = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            we,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [THR_W-1:0]                wdata,
  output logic [NUM_THR-1:0][THR_W-1:0]   thr_q
);
  for (genvar g = 0; g < NUM_THR; g++) begin : g_thr
    always_ff @(posedge clk) begin
      if (rst)
        thr_q[g] <= THR_W'(RESET_VAL);
      else if (we && addr == ADDR_W'(g))
        thr_q[g] <= wdata;
    end
  end
endmodule

// File: rtl/trig_rx_cmp.sv
module trig_rx_cmp
  import uart_trig_pkg::*;
#(
  parameter int unsigned LVL_W = 8,
  parameter int unsigned THR_W = 7
) (
  input  logic             enh_en,
  input  logic [THR_W-1:0] prog_thr,
  input  logic [1:0]       legacy_sel,
  input  logic             ie,
  input  logic [LVL_W-1:0] level,
  output logic             irq
);
  logic [THR_W-1:0] eff_thr;

  always_comb begin
    eff_thr = enh_en ? prog_thr : THR_W'(legacy_rx_thr(legacy_sel));
    irq     = ie && (level >= LVL_W'(eff_thr));
  end
endmodule

// File: rtl/trig_tx_cmp.sv
module trig_tx_cmp
  import uart_trig_pkg::*;
#(
  parameter int unsigned LVL_W = 8,
  parameter int unsigned THR_W = 7
) (
  input  logic             enh_en,
  input  logic [THR_W-1:0] prog_thr,
  input  logic [1:0]       legacy_sel,
  input  logic             ie,
  input  logic [LVL_W-1:0] level,
  input  logic             tsr_empty,
  input  logic             line_idle,
  output logic             irq
);
  logic [THR_W-1:0] eff_thr;
  logic             drained;
  logic             drain_mode;

  always_comb begin
    eff_thr    = enh_en ? prog_thr : THR_W'(legacy_tx_thr(legacy_sel));
    drained    = (level == '0) && tsr_empty && line_idle;
    drain_mode = enh_en && (prog_thr == '0);
    if (drain_mode)
      irq = ie && drained;
    else
      irq = ie && (level < LVL_W'(eff_thr));
  end
endmodule

// File: rtl/uart_fifo_irq_trig.sv
module uart_fifo_irq_trig
  import uart_trig_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 128,
  parameter int unsigned THR_W      = 7,
  localparam int unsigned LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic             reg_addr,
  input  logic [THR_W-1:0] reg_wdata,
  input  logic             enh_en,
  input  logic [1:0]       rx_lvl_sel,
  input  logic [1:0]       tx_lvl_sel,
  input  logic             rx_ie,
  input  logic             tx_ie,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_level,
  input  logic             tsr_empty,
  input  logic             line_idle,
  output logic             rx_irq,
  output logic             tx_irq,
  output logic [1:0]       rx_prio,
  output logic [1:0]       tx_prio
);
  localparam int unsigned NUM_THR = 2;

  logic [NUM_THR-1:0][THR_W-1:0] thr_q;
  logic [THR_W-1:0]              rx_thr_q;
  logic [THR_W-1:0]              tx_thr_q;

  trig_thr_regs #(.THR_W(THR_W), .NUM_THR(NUM_THR), .RESET_VAL(1)) regs_i (
    .clk   (clk),
    .rst   (rst),
    .we    (reg_we),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .thr_q (thr_q)
  );

  assign rx_thr_q = thr_q[RX_IDX];
  assign tx_thr_q = thr_q[TX_IDX];

  trig_rx_cmp #(.LVL_W(LVL_W), .THR_W(THR_W)) rx_cmp_i (
    .enh_en     (enh_en),
    .prog_thr   (rx_thr_q),
    .legacy_sel (rx_lvl_sel),
    .ie         (rx_ie),
    .level      (rx_level),
    .irq        (rx_irq)
  );

  trig_tx_cmp #(.LVL_W(LVL_W), .THR_W(THR_W)) tx_cmp_i (
    .enh_en     (enh_en),
    .prog_thr   (tx_thr_q),
    .legacy_sel (tx_lvl_sel),
    .ie         (tx_ie),
    .level      (tx_level),
    .tsr_empty  (tsr_empty),
    .line_idle  (line_idle),
    .irq        (tx_irq)
  );

  assign rx_prio = rx_irq ? RX_PRIO : 2'd0;
  assign tx_prio = tx_irq ? TX_PRIO : 2'd0;
endmodule

// File: rtl/uart_trig_chk.sv
module uart_trig_chk #(
  parameter int unsigned FIFO_DEPTH = 128,
  parameter int unsigned THR_W      = 7,
  localparam int unsigned LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_we,
  input logic             reg_addr,
  input logic [THR_W-1:0] reg_wdata,
  input logic             enh_en,
  input logic             rx_ie,
  input logic             tx_ie,
  input logic [LVL_W-1:0] rx_level,
  input logic [LVL_W-1:0] tx_level,
  input logic             tsr_empty,
  input logic             line_idle,
  input logic             rx_irq,
  input logic             tx_irq,
  input logic [1:0]       rx_prio,
  input logic [1:0]       tx_prio,
  input logic [THR_W-1:0] rx_thr,
  input logic [THR_W-1:0] tx_thr
);
  p_rx_masked_r1: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> rx_ie);

  p_rx_reach_r1: assert property (@(posedge clk) disable iff (rst)
    (enh_en && rx_ie && rx_level >= LVL_W'(rx_thr)) |-> rx_irq);

  p_tx_masked_r2: assert property (@(posedge clk) disable iff (rst)
    tx_irq |-> tx_ie);

  p_tx_below_r2: assert property (@(posedge clk) disable iff (rst)
    (enh_en && tx_thr != '0 && tx_irq) |-> (tx_level < LVL_W'(tx_thr)));

  p_tx_drain_r3: assert property (@(posedge clk) disable iff (rst)
    (enh_en && tx_thr == '0 && tx_irq) |-> (tx_level == '0 && tsr_empty && line_idle));

  p_legacy_rx_r5: assert property (@(posedge clk) disable iff (rst)
    (!enh_en && rx_irq) |-> (rx_level != '0));

  p_legacy_tx_r6: assert property (@(posedge clk) disable iff (rst)
    (!enh_en && tx_irq) |-> (tx_level < LVL_W'(112)));

  p_rx_prio_r7: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> (rx_prio == 2'd2));

  p_tx_prio_r7: assert property (@(posedge clk) disable iff (rst)
    tx_irq |-> (tx_prio == 2'd3));

  p_rx_wr_r9: assert property (@(posedge clk) disable iff (rst)
    (reg_we && !reg_addr) |=> (rx_thr == $past(reg_wdata)));

  p_tx_wr_r9: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr) |=> (tx_thr == $past(reg_wdata)));
endmodule

bind uart_fifo_irq_trig uart_trig_chk #(.FIFO_DEPTH(FIFO_DEPTH), .THR_W(THR_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .enh_en    (enh_en),
  .rx_ie     (rx_ie),
  .tx_ie     (tx_ie),
  .rx_level  (rx_level),
  .tx_level  (tx_level),
  .tsr_empty (tsr_empty),
  .line_idle (line_idle),
  .rx_irq    (rx_irq),
  .tx_irq    (tx_irq),
  .rx_prio   (rx_prio),
  .tx_prio   (tx_prio),
  .rx_thr    (rx_thr_q),
  .tx_thr    (tx_thr_q)
);

// File: tb/uart_fifo_irq_trig_tb_top.sv
`timescale 1ns/1ps
module uart_fifo_irq_trig_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0;
  logic       reg_addr = 1'b0;
  logic [6:0] reg_wdata = '0;
  logic       enh_en = 1'b1;
  logic [1:0] rx_lvl_sel = '0;
  logic [1:0] tx_lvl_sel = '0;
  logic       rx_ie = 1'b0;
  logic       tx_ie = 1'b0;
  logic [7:0] rx_level = '0;
  logic [7:0] tx_level = '0;
  logic       tsr_empty = 1'b0;
  logic       line_idle = 1'b0;
  logic       rx_irq, tx_irq;
  logic [1:0] rx_prio, tx_prio;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit checks_on = 1'b0;
  bit done = 1'b0;
  int m_rx_thr = 1;
  int m_tx_thr = 1;

  always #2 clk = ~clk;

  uart_fifo_irq_trig dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .enh_en(enh_en), .rx_lvl_sel(rx_lvl_sel), .tx_lvl_sel(tx_lvl_sel),
    .rx_ie(rx_ie), .tx_ie(tx_ie), .rx_level(rx_level), .tx_level(tx_level),
    .tsr_empty(tsr_empty), .line_idle(line_idle),
    .rx_irq(rx_irq), .tx_irq(tx_irq), .rx_prio(rx_prio), .tx_prio(tx_prio)
  );

  // Reference thresholds: reset to 1 (R10), written on reg_we (R9)
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst) begin
      m_rx_thr <= 1;
      m_tx_thr <= 1;
    end else if (reg_we) begin
      if (reg_addr) m_tx_thr <= int'(reg_wdata);
      else          m_rx_thr <= int'(reg_wdata);
    end
  end

  function automatic int leg_rx(input logic [1:0] s);
    int t[4] = '{1, 32, 64, 112};
    return t[s];
  endfunction

  function automatic int leg_tx(input logic [1:0] s);
    int t[4] = '{16, 32, 64, 112};
    return t[s];
  endfunction

  task automatic check1(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  // Per-cycle comparison, away from the rising edge (R8: same-cycle response)
  always @(negedge clk) begin
    if (checks_on && !done) begin
      bit erx, etx;
      string trx, ttx;
      if (enh_en) begin
        erx = rx_ie && (int'(rx_level) >= m_rx_thr);
        trx = "R1 R4 R8 R9 R10";
        if (m_tx_thr == 0) begin
          etx = tx_ie && rx_level >= 0 && tx_level == 0 && tsr_empty && line_idle;
          ttx = "R3 R4 R8 R9";
        end else begin
          etx = tx_ie && (int'(tx_level) < m_tx_thr);
          ttx = "R2 R4 R8 R9 R10";
        end
      end else begin
        erx = rx_ie && (int'(rx_level) >= leg_rx(rx_lvl_sel));
        etx = tx_ie && (int'(tx_level) < leg_tx(tx_lvl_sel));
        trx = "R5 R8";
        ttx = "R6 R8";
      end
      check1(trx, int'(rx_irq), int'(erx));
      check1(ttx, int'(tx_irq), int'(etx));
      check1("R7 rx_prio", int'(rx_prio), erx ? 2 : 0);
      check1("R7 tx_prio", int'(tx_prio), etx ? 3 : 0);
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input bit a, input int v);
    reg_we = 1'b1; reg_addr = a; reg_wdata = 7'(v);
    tick();
    reg_we = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    while (cycles < 150000 && !done) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R8 watchdog expired actual=%0d expected<150000", cycles);
      finish_run();
    end
  end

  initial begin
    tick();
    checks_on = 1'b1;
    tick(); tick();
    rst = 1'b0;
    // R10: reset thresholds of 1 in enhanced mode
    enh_en = 1'b1; rx_ie = 1'b1; tx_ie = 1'b1;
    rx_level = 0; tx_level = 0; tick();
    rx_level = 1; tx_level = 1; tick();
    rx_level = 2; tx_level = 0; tick();
    // R1 R2 R4: programmed thresholds, boundaries, legacy fields varied
    wr(1'b0, 64); wr(1'b1, 20);
    for (int d = -2; d <= 2; d++) begin
      for (int s = 0; s < 4; s++) begin
        rx_lvl_sel = 2'(s); tx_lvl_sel = 2'(3 - s);
        rx_level = 8'(64 + d); tx_level = 8'(20 + d);
        tick();
      end
    end
    // R1 R2: enable masks
    rx_ie = 1'b0; tx_ie = 1'b0; rx_level = 100; tx_level = 0; tick();
    rx_ie = 1'b1; tick();
    tx_ie = 1'b1; tick();
    // R1: maximum threshold and full FIFO
    wr(1'b0, 127); rx_level = 127; tick(); rx_level = 126; tick(); rx_level = 128; tick();
    // R3: transmit threshold zero, all drain combinations
    wr(1'b1, 0);
    for (int c = 0; c < 16; c++) begin
      tx_level = (c & 1) ? 8'd1 : 8'd0;
      tsr_empty = c[1]; line_idle = c[2]; tx_ie = ~c[3];
      tick();
    end
    // R5 R6: legacy tables at boundaries
    enh_en = 1'b0; rx_ie = 1'b1; tx_ie = 1'b1;
    for (int s = 0; s < 4; s++) begin
      rx_lvl_sel = 2'(s); tx_lvl_sel = 2'(s);
      for (int d = -1; d <= 1; d++) begin
        rx_level = 8'(leg_rx(2'(s)) + d);
        tx_level = 8'(leg_tx(2'(s)) + d);
        tick();
      end
      tx_level = 0; tsr_empty = 1'b0; line_idle = 1'b0; tick();
    end
    // Mixed random traffic with writes, including zero thresholds
    for (int i = 0; i < 4000; i++) begin
      enh_en = ($urandom_range(0, 3) != 0);
      rx_lvl_sel = 2'($urandom); tx_lvl_sel = 2'($urandom);
      rx_ie = ($urandom_range(0, 4) != 0); tx_ie = ($urandom_range(0, 4) != 0);
      rx_level = 8'($urandom_range(0, 128));
      tx_level = ($urandom_range(0, 3) == 0) ? 8'd0 : 8'($urandom_range(0, 128));
      tsr_empty = 1'($urandom); line_idle = 1'($urandom);
      if ($urandom_range(0, 9) == 0)
        wr(1'($urandom), ($urandom_range(0, 3) == 0) ? 0 : int'($urandom_range(0, 127)));
      else
        tick();
    end
    // R10: reset mid-run restores thresholds of 1
    rst = 1'b1; enh_en = 1'b1; tick(); tick();
    rst = 1'b0; rx_level = 1; tx_level = 0; rx_ie = 1'b1; tx_ie = 1'b1; tick();
    rx_level = 0; tx_level = 1; tick();
    @(negedge clk); #1;
    finish_run();
  end
endmodule